// File: doc/BRIEF.md
# Processor Serial Transmit Port with Host Mailbox Status

This block gives an embedded processor a one-byte transmit port towards a neighbouring device and a status byte that also tracks a pair of one-byte mailboxes shared with a USB host. A processor write to the transmit offset starts an asynchronous serial frame if the transmitter is idle. If the transmitter is still busy, the byte is dropped and a sticky overrun flag is raised. The flag stays up until a later write is accepted while the transmitter is idle.

The mailbox data bytes live in a shared memory outside this block. This block keeps only their occupancy flags. The host reaches the mailboxes through I2C sub-addresses and presents each completed access as a one-cycle event with its sub-address. The processor reaches the same two bytes through shared-area offsets. The outgoing mailbox (0x61) fills on a processor write and empties on a host read. The incoming mailbox (0x60) fills on a host write and empties on a processor read.

Top module: `sermbx_top`

## Requirements
- R1: After reset the status byte is 0x80 (transmitter ready, all flags clear) and the serial line is high.
- R2: A processor write to offset TX_ADDR (0xFC) while the transmitter is ready starts a frame in the cycle after the write. The frame is a low start bit, eight data bits LSB first and a high stop bit, each bit held for CLKS_PER_BIT cycles. The line is high whenever no frame is in progress.
- R3: Status bit 7 reads 0 for exactly 10*CLKS_PER_BIT cycles after an accepted write, and then reads 1 again.
- R4: A write to TX_ADDR while status bit 7 is 0 is discarded. The frame in progress continues unchanged, and status bit 6 (overrun) reads 1 from the next cycle.
- R5: Status bit 6 holds its value until a write to TX_ADDR is accepted while the transmitter is ready. That write clears it in the next cycle.
- R6: Status bit 5 is set by a processor write to offset 0x61 and cleared by a host read of sub-address 0x61. If both happen in the same cycle, the set wins.
- R7: Status bit 4 is set by a host write to sub-address 0x60 and cleared by a processor read of offset 0x60. If both happen in the same cycle, the set wins.
- R8: Status bits 3 to 0 always read 0.
- R9: Accesses to any other offset or sub-address, and accesses in the wrong direction to 0x60 or 0x61, leave the status byte and the serial line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Processor write strobe, one cycle |
| cpu_rd | input | 1 | Processor read strobe, one cycle |
| cpu_addr | input | ADDR_W | Processor offset |
| cpu_wdata | input | 8 | Processor write data |
| host_wr | input | 1 | Host I2C write event, one cycle |
| host_rd | input | 1 | Host I2C read event, one cycle |
| host_sub | input | ADDR_W | Host I2C sub-address |
| txd | output | 1 | Serial line to the neighbouring device |
| status | output | 8 | {ready, overrun, out-mailbox full, in-mailbox full, 4'b0} |

## Verification
The bench builds the block with CLKS_PER_BIT = 4, so each frame lasts 40 cycles. This short frame makes it practical to send every one of the 256 byte values and to compare the line against a frame computed in the bench on every cycle. On a selection of those frames, a second write is injected at varying depths into the busy window. This shows that the overrun flag is set, that it survives until the next accepted write, and that the frame in progress is not disturbed. The mailbox flags are checked for their set and clear events, for same-cycle collisions, and for wrong-direction or off-address accesses.

// File: rtl/sermbx_pkg.sv
package sermbx_pkg;
  localparam int FRAME_BITS = 10;
  localparam int ST_READY   = 7;
  localparam int ST_OVR     = 6;
  localparam int ST_OUTFULL = 5;
  localparam int ST_INFULL  = 4;

  function automatic logic [FRAME_BITS-1:0] frame_of(input logic [7:0] b);
    return {1'b1, b, 1'b0};
  endfunction

  function automatic logic [7:0] pack_status(input logic rdy, input logic ovr,
                                             input logic ofull, input logic ifull);
    return {rdy, ovr, ofull, ifull, 4'b0000};
  endfunction
endpackage

// File: rtl/sermbx_flag.sv
module sermbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= 1'b0;
    else if (set_i)  q <= 1'b1;
    else if (clr_i)  q <= 1'b0;
  end
endmodule

// File: rtl/sermbx_uart_tx.sv
module sermbx_uart_tx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] data,
  output logic       ready,
  output logic       txd
);
  import sermbx_pkg::*;
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;

  logic                  busy;
  logic [CW-1:0]         baud;
  logic [3:0]            bitn;
  logic [FRAME_BITS-1:0] sh;
  logic                  bit_end;

  assign bit_end = (baud == CW'(CLKS_PER_BIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      baud <= '0;
      bitn <= '0;
      sh   <= '1;
    end else if (load && !busy) begin
      busy <= 1'b1;
      baud <= '0;
      bitn <= '0;
      sh   <= frame_of(data);
    end else if (busy) begin
      if (bit_end) begin
        baud <= '0;
        sh   <= {1'b1, sh[FRAME_BITS-1:1]};
        if (bitn == 4'(FRAME_BITS - 1)) busy <= 1'b0;
        else                            bitn <= bitn + 4'd1;
      end else begin
        baud <= baud + CW'(1);
      end
    end
  end

  assign ready = !busy;
  assign txd   = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/sermbx_top.sv
module sermbx_top #(
  parameter int              CLKS_PER_BIT = 16,
  parameter int              ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] TX_ADDR    = 8'hFC,
  parameter logic [ADDR_W-1:0] MBX_OUT    = 8'h61,
  parameter logic [ADDR_W-1:0] MBX_IN     = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_sub,
  output logic              txd,
  output logic [7:0]        status
);
  import sermbx_pkg::*;

  logic tx_wr_evt, tx_ready, tx_accept, tx_reject;
  logic out_set, out_clr, in_set, in_clr;
  logic ovr_q, out_full, in_full;

  assign tx_wr_evt = cpu_wr && (cpu_addr == TX_ADDR);
  assign tx_accept = tx_wr_evt && tx_ready;
  assign tx_reject = tx_wr_evt && !tx_ready;
  assign out_set   = cpu_wr  && (cpu_addr == MBX_OUT);
  assign out_clr   = host_rd && (host_sub == MBX_OUT);
  assign in_set    = host_wr && (host_sub == MBX_IN);
  assign in_clr    = cpu_rd  && (cpu_addr == MBX_IN);

  sermbx_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_accept), .data(cpu_wdata),
    .ready(tx_ready), .txd(txd)
  );

  sermbx_flag u_ovr  (.clk(clk), .rst_n(rst_n), .set_i(tx_reject), .clr_i(tx_accept), .q(ovr_q));
  sermbx_flag u_out  (.clk(clk), .rst_n(rst_n), .set_i(out_set),   .clr_i(out_clr),   .q(out_full));
  sermbx_flag u_in   (.clk(clk), .rst_n(rst_n), .set_i(in_set),    .clr_i(in_clr),    .q(in_full));

  assign status = pack_status(tx_ready, ovr_q, out_full, in_full);
endmodule

// File: rtl/sermbx_chk.sv
module sermbx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_wr_evt,
  input logic       out_set,
  input logic       out_clr,
  input logic       in_set,
  input logic       in_clr,
  input logic       txd,
  input logic [7:0] status
);
  assert_rsv_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status[3:0] == 4'b0000);
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |-> txd);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_evt && status[7]) |=> (!txd && !status[7]));
  assert_ovr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_evt && !status[7]) |=> status[6]);
  assert_ovr_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_evt && status[7]) |=> !status[6]);
  assert_ovr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_wr_evt |=> $stable(status[6]));
  assert_out_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_set |=> status[5]);
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_set && !out_clr) |=> $stable(status[5]));
  assert_in_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_set |=> status[4]);
  assert_in_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_clr && !in_set) |=> !status[4]);
endmodule

bind sermbx_top sermbx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr_evt(tx_wr_evt),
  .out_set(out_set), .out_clr(out_clr), .in_set(in_set), .in_clr(in_clr),
  .txd(txd), .status(status)
);

// File: tb/tb_sermbx_top.sv
module tb_sermbx_top;
  localparam int D = 4;
  localparam logic [7:0] TXA = 8'hFC, MOUT = 8'h61, MIN = 8'h60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr = 0, cpu_rd = 0, host_wr = 0, host_rd = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0, host_sub = 0;
  logic txd;
  logic [7:0] status;
  int checks = 0, fails = 0;
  logic ovr_exp = 0;

  always #2.5 clk = ~clk;

  sermbx_top #(.CLKS_PER_BIT(D)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .host_wr(host_wr),
    .host_rd(host_rd), .host_sub(host_sub), .txd(txd), .status(status)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input logic [7:0] b, input int idx);
    if (idx == 0) return 1'b0;
    if (idx == 9) return 1'b1;
    return b[idx-1];
  endfunction

  // one-cycle access; starts and ends at a negedge
  task automatic pulse(input logic w, input logic r, input logic [7:0] a,
                       input logic hw, input logic hr, input logic [7:0] s);
    cpu_wr = w; cpu_rd = r; cpu_addr = a; cpu_wdata = 8'h5A;
    host_wr = hw; host_rd = hr; host_sub = s;
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0; host_wr = 0; host_rd = 0;
  endtask

  // send byte b; optionally inject a busy write at cycle inj
  task automatic frame(input logic [7:0] b, input int inj);
    cpu_wr = 1; cpu_addr = TXA; cpu_wdata = b;
    @(negedge clk);
    cpu_wr = 0;
    ovr_exp = 0;
    for (int j = 0; j <= 10*D; j++) begin
      if (j == inj + 1) ovr_exp = 1;
      if (j < 10*D) begin
        chk("R2 txd", {7'b0, txd}, {7'b0, exp_bit(b, j / D)});
        chk("R3 busy", {7'b0, status[7]}, 8'h00);
      end else begin
        chk("R3 ready again", {7'b0, status[7]}, 8'h01);
        chk("R2 idle line", {7'b0, txd}, 8'h01);
      end
      chk("R4/R5 overrun", {7'b0, status[6]}, {7'b0, ovr_exp});
      chk("R8 reserved", {4'b0, status[3:0]}, 8'h00);
      cpu_wr = (j == inj); cpu_addr = TXA; cpu_wdata = ~b;
      @(negedge clk);
    end
    cpu_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset status", status, 8'h80);
    chk("R1 reset txd", {7'b0, txd}, 8'h01);
    for (int b = 0; b < 256; b++)
      frame(8'(b), (b % 8 == 3) ? (b % 37) + 1 : -5);
    chk("R5 cleared by accepted write", status, 8'h80);
    // R9: other offsets and wrong-direction accesses
    pulse(1, 0, 8'h55, 0, 0, 8'h00);
    chk("R9 other offset write", status, 8'h80);
    chk("R9 line idle", {7'b0, txd}, 8'h01);
    pulse(0, 0, 8'h00, 1, 0, MOUT);
    chk("R9 host write 0x61", status, 8'h80);
    pulse(0, 1, MOUT, 0, 0, 8'h00);
    chk("R9 cpu read 0x61", status, 8'h80);
    pulse(1, 0, MIN, 0, 1, MIN);
    chk("R9 cpu write/host read 0x60", status, 8'h80);
    // R6 outgoing mailbox
    pulse(1, 0, MOUT, 0, 0, 8'h00);
    chk("R6 set", status, 8'hA0);
    pulse(0, 0, 8'h00, 0, 1, MIN);
    chk("R6 hold on other sub", status, 8'hA0);
    pulse(0, 0, 8'h00, 0, 1, MOUT);
    chk("R6 clear", status, 8'h80);
    pulse(1, 0, MOUT, 0, 1, MOUT);
    chk("R6 collide from empty", status, 8'hA0);
    pulse(1, 0, MOUT, 0, 1, MOUT);
    chk("R6 collide from full", status, 8'hA0);
    // R7 incoming mailbox
    pulse(0, 0, 8'h00, 1, 0, MIN);
    chk("R7 set", status, 8'hB0);
    pulse(0, 1, 8'h33, 0, 0, 8'h00);
    chk("R7 hold on other offset", status, 8'hB0);
    pulse(0, 1, MIN, 0, 0, 8'h00);
    chk("R7 clear", status, 8'hA0);
    pulse(0, 1, MIN, 1, 0, MIN);
    chk("R7 collide", status, 8'hB0);
    pulse(0, 0, 8'h00, 0, 1, MOUT);
    pulse(0, 1, MIN, 0, 0, 8'h00);
    chk("R6/R7 both empty", status, 8'h80);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule